// File: doc/BRIEF.md
# Inter-Processor Command Dispatcher

This block turns one software write into one command aimed at one processor core. Each write holds three fields: a command kind, the number of the target core, and a six-bit vector. The four command kinds are: post an interrupt carrying the vector, start the core from power-on reset, halt the core, and resume the core. Each command that the block accepts appears on the cycle after the write as a one-cycle pulse on the output for that kind. The core number and vector come out with the pulse.

The block keeps one run bit per core, and the cores read that mask to see which of them should be executing. A write aimed at a core number beyond the installed count is dropped. A start command is carried out only when its vector equals the configured power-on-reset code. Any other start request is refused and raises a sticky error flag. The cores themselves are outside the block.

Top module: `ipi_dispatch`

## Requirements
- R1: After reset all four command pulses are low, `cmdCpu` and `cmdVector` are zero, every bit of `runMask` is one, and `startErr` is zero.
- R2: The command kind is taken from `wrData[17:16]` (0 = post, 1 = start, 2 = halt, 3 = resume), the core from `wrData[12:8]` and the vector from `wrData[5:0]`. The remaining bits have no effect.
- R3: A post write to an installed core raises `postPulse` in the cycle after the write, with `cmdCpu` and `cmdVector` equal to the written core and vector. `runMask` does not change.
- R4: A start write whose vector equals `POR_CODE` (default 6'h01) raises `startPulse` in the cycle after the write and sets the target core's `runMask` bit.
- R5: A start write whose vector differs from `POR_CODE` raises no pulse, leaves `runMask`, `cmdCpu` and `cmdVector` unchanged, and sets `startErr`.
- R6: A halt write raises `haltPulse` in the cycle after the write and clears the target core's `runMask` bit.
- R7: A resume write raises `resumePulse` in the cycle after the write and sets the target core's `runMask` bit.
- R8: A write whose core number is not less than `NUM_CPUS` is dropped. It produces no pulse and leaves `runMask`, `startErr`, `cmdCpu` and `cmdVector` as they were.
- R9: At most one pulse is high in any cycle, and each pulse lasts one cycle per accepted write. In a cycle with no accepted write in the cycle before, all pulses are low and `cmdCpu` and `cmdVector` keep their last values.
- R10: `startErr` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Dispatch write valid |
| wrData | input | 18 | Dispatch write data (kind, core, vector) |
| postPulse | output | 1 | Post-interrupt command pulse |
| startPulse | output | 1 | Power-on start command pulse |
| haltPulse | output | 1 | Halt command pulse |
| resumePulse | output | 1 | Resume command pulse |
| cmdCpu | output | 5 | Target core of the last accepted command |
| cmdVector | output | 6 | Vector of the last accepted command |
| runMask | output | NUM_CPUS | Per-core run bit |
| startErr | output | 1 | Sticky flag for a refused start request |

## Verification
Directed writes check each command kind on its own. A post to a halted core shows that posting and running are separate. A start with the wrong vector is separated from one with the power-on code. Writes to core numbers just at and well above the installed count show that the range filter uses the count and not the field width. Writes with junk in the unused bit positions show that only the three fields are decoded. A long random stream then mixes all four kinds, back-to-back and idle cycles, and in-range and out-of-range targets. It checks that pulses never overlap or linger, that the run mask follows every halt, start and resume, and that the error flag never clears until a reset partway through the run.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int KIND_LSB = 16;
  localparam int KIND_W   = 2;
  localparam int CPU_LSB  = 8;
  localparam int VEC_LSB  = 0;

  typedef enum logic [KIND_W-1:0] {
    KIND_POST   = 2'd0,
    KIND_START  = 2'd1,
    KIND_HALT   = 2'd2,
    KIND_RESUME = 2'd3
  } cmdKind_e;

  typedef struct packed {
    logic post;
    logic start;
    logic halt;
    logic resume;
    logic badStart;
  } ctrlStrobe_t;

endpackage

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int             NUM_CPUS = 8,
  parameter int             CPU_W    = 5,
  parameter int             VEC_W    = 6,
  parameter int             WR_W     = 18,
  parameter logic [VEC_W-1:0] POR_CODE = 6'h01
) (
  input  logic              wrEn,
  input  logic [WR_W-1:0]   wrData,
  output ctrlStrobe_t       ctrl,
  output logic [CPU_W-1:0]  tgtCpu,
  output logic [VEC_W-1:0]  tgtVec
);

  localparam logic [CPU_W:0] CPU_LIMIT = (CPU_W+1)'(NUM_CPUS);

  cmdKind_e kind;
  logic     inRange;

  assign kind    = cmdKind_e'(wrData[KIND_LSB +: KIND_W]);
  assign tgtCpu  = wrData[CPU_LSB +: CPU_W];
  assign tgtVec  = wrData[VEC_LSB +: VEC_W];
  assign inRange = {1'b0, tgtCpu} < CPU_LIMIT;

  always_comb begin
    ctrl = '0;
    if (wrEn && inRange) begin
      unique case (kind)
        KIND_POST:   ctrl.post = 1'b1;
        KIND_START: begin
          if (tgtVec == POR_CODE) ctrl.start    = 1'b1;
          else                    ctrl.badStart = 1'b1;
        end
        KIND_HALT:   ctrl.halt   = 1'b1;
        KIND_RESUME: ctrl.resume = 1'b1;
        default:     ctrl = '0;
      endcase
    end
  end

endmodule

// File: rtl/ipi_datapath.sv
module ipi_datapath
  import ipi_pkg::*;
#(
  parameter int NUM_CPUS = 8,
  parameter int CPU_W    = 5,
  parameter int VEC_W    = 6
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         ctrl,
  input  logic [CPU_W-1:0]    tgtCpu,
  input  logic [VEC_W-1:0]    tgtVec,
  output logic                postPulse,
  output logic                startPulse,
  output logic                haltPulse,
  output logic                resumePulse,
  output logic [CPU_W-1:0]    cmdCpu,
  output logic [VEC_W-1:0]    cmdVector,
  output logic [NUM_CPUS-1:0] runMask,
  output logic                startErr
);

  logic accepted;
  assign accepted = ctrl.post | ctrl.start | ctrl.halt | ctrl.resume;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postPulse   <= 1'b0;
      startPulse  <= 1'b0;
      haltPulse   <= 1'b0;
      resumePulse <= 1'b0;
    end else begin
      postPulse   <= ctrl.post;
      startPulse  <= ctrl.start;
      haltPulse   <= ctrl.halt;
      resumePulse <= ctrl.resume;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdCpu    <= '0;
      cmdVector <= '0;
    end else if (accepted) begin
      cmdCpu    <= tgtCpu;
      cmdVector <= tgtVec;
    end
  end

  for (genvar g = 0; g < NUM_CPUS; g++) begin : g_run
    logic hit;
    assign hit = (tgtCpu == CPU_W'(g));
    always_ff @(posedge clk) begin
      if (!rstN)                                runMask[g] <= 1'b1;
      else if (hit && (ctrl.start || ctrl.resume)) runMask[g] <= 1'b1;
      else if (hit && ctrl.halt)                runMask[g] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              startErr <= 1'b0;
    else if (ctrl.badStart) startErr <= 1'b1;
  end

  logic tgtRun;
  assign tgtRun = runMask[cmdCpu[$clog2(NUM_CPUS > 1 ? NUM_CPUS : 2)-1:0]];

  AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({postPulse, startPulse, haltPulse, resumePulse})); // R9
  AST_HALT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    haltPulse |-> !tgtRun); // R6
  AST_START_SETS: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |-> tgtRun); // R4
  AST_RESUME_SETS: assert property (@(posedge clk) disable iff (!rstN)
    resumePulse |-> tgtRun); // R7
  AST_POST_KEEPS_RUN: assert property (@(posedge clk) disable iff (!rstN)
    postPulse |-> runMask == $past(runMask)); // R3
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    startErr |=> startErr); // R10

endmodule

// File: rtl/ipi_dispatch.sv
module ipi_dispatch
  import ipi_pkg::*;
#(
  parameter int               NUM_CPUS = 8,
  parameter int               CPU_W    = 5,
  parameter int               VEC_W    = 6,
  parameter int               WR_W     = 18,
  parameter logic [VEC_W-1:0] POR_CODE = 6'h01
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                wrEn,
  input  logic [WR_W-1:0]     wrData,
  output logic                postPulse,
  output logic                startPulse,
  output logic                haltPulse,
  output logic                resumePulse,
  output logic [CPU_W-1:0]    cmdCpu,
  output logic [VEC_W-1:0]    cmdVector,
  output logic [NUM_CPUS-1:0] runMask,
  output logic                startErr
);

  ctrlStrobe_t      ctrl;
  logic [CPU_W-1:0] tgtCpu;
  logic [VEC_W-1:0] tgtVec;

  ipi_ctrl #(
    .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W), .VEC_W(VEC_W),
    .WR_W(WR_W), .POR_CODE(POR_CODE)
  ) u_ctrl (
    .wrEn(wrEn), .wrData(wrData), .ctrl(ctrl),
    .tgtCpu(tgtCpu), .tgtVec(tgtVec)
  );

  ipi_datapath #(
    .NUM_CPUS(NUM_CPUS), .CPU_W(CPU_W), .VEC_W(VEC_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .tgtCpu(tgtCpu), .tgtVec(tgtVec),
    .postPulse(postPulse), .startPulse(startPulse), .haltPulse(haltPulse),
    .resumePulse(resumePulse), .cmdCpu(cmdCpu), .cmdVector(cmdVector),
    .runMask(runMask), .startErr(startErr)
  );

  logic wrOut;
  logic wrBadStart;
  assign wrOut = wrEn &&
    ({1'b0, wrData[CPU_LSB +: CPU_W]} >= (CPU_W+1)'(NUM_CPUS));
  assign wrBadStart = wrEn && !wrOut &&
    (wrData[KIND_LSB +: KIND_W] == KIND_START) &&
    (wrData[VEC_LSB +: VEC_W] != POR_CODE);

  AST_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    wrOut |=> !(postPulse || startPulse || haltPulse || resumePulse)
              && $stable(runMask) && $stable(startErr)); // R8
  AST_BAD_START: assert property (@(posedge clk) disable iff (!rstN)
    wrBadStart |=> startErr && !startPulse && $stable(runMask)); // R5

endmodule

// File: tb/ipi_dispatch_test.sv
module ipi_dispatch_test;

  localparam int NUM = 8;
  localparam logic [5:0] POR = 6'h01;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [17:0] wrData = '0;
  logic        postPulse, startPulse, haltPulse, resumePulse;
  logic [4:0]  cmdCpu;
  logic [5:0]  cmdVector;
  logic [NUM-1:0] runMask;
  logic        startErr;

  ipi_dispatch #(.NUM_CPUS(NUM), .POR_CODE(POR)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrData(wrData),
    .postPulse(postPulse), .startPulse(startPulse), .haltPulse(haltPulse),
    .resumePulse(resumePulse), .cmdCpu(cmdCpu), .cmdVector(cmdVector),
    .runMask(runMask), .startErr(startErr)
  );

  always #10 clk = ~clk;

  int nChecks = 0;
  int nFails  = 0;

  logic [3:0]     expPulse;   // {resume, halt, start, post}
  logic [4:0]     expCpu;
  logic [5:0]     expVec;
  logic [NUM-1:0] expRun;
  logic           expErr;
  string          tag;

  task automatic check(input string t, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", t, what, act, exp);
    end
  endtask

  task automatic checkOutputs();
    check(tag, "pulses", {resumePulse, haltPulse, startPulse, postPulse}, expPulse);
    check(tag, "cmdCpu", cmdCpu, expCpu);
    check(tag, "cmdVector", cmdVector, expVec);
    check(tag, "runMask", runMask, expRun);
    check(expErr ? "R10" : "R5", "startErr", startErr, expErr);
  endtask

  task automatic modelReset();
    expPulse = '0; expCpu = '0; expVec = '0; expRun = '1; expErr = 1'b0;
    tag = "R1";
  endtask

  // R2: fields at [17:16], [12:8], [5:0]
  task automatic modelWrite(input logic en, input logic [17:0] d);
    logic [1:0] k = d[17:16];
    logic [4:0] c = d[12:8];
    logic [5:0] v = d[5:0];
    expPulse = '0;
    tag = "R9";
    if (!en) return;
    if (int'(c) >= NUM) begin tag = "R8"; return; end
    case (k)
      2'd0: begin expPulse[0] = 1; expCpu = c; expVec = v; tag = "R3"; end
      2'd1: begin
        if (v == POR) begin
          expPulse[1] = 1; expCpu = c; expVec = v; expRun[c] = 1'b1; tag = "R4";
        end else begin
          expErr = 1'b1; tag = "R5";
        end
      end
      2'd2: begin expPulse[2] = 1; expCpu = c; expVec = v; expRun[c] = 1'b0; tag = "R6"; end
      default: begin expPulse[3] = 1; expCpu = c; expVec = v; expRun[c] = 1'b1; tag = "R7"; end
    endcase
  endtask

  task automatic step(input logic en, input logic [17:0] d);
    @(negedge clk);
    checkOutputs();
    wrEn = en; wrData = d;
    modelWrite(en, d);
  endtask

  function automatic logic [17:0] mk(input int k, input int c, input int v);
    return {2'(k), 3'b000, 5'(c), 2'b00, 6'(v)};
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; wrEn = 1'b0;
    modelReset();
    @(negedge clk);
    checkOutputs();   // R1
    rstN = 1'b1;
    tag = "R9";
  endtask

  initial begin
    #(20 * 150000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    modelReset();
    repeat (2) @(negedge clk);
    checkOutputs();   // R1 reset state
    rstN = 1'b1;
    tag = "R9";

    // directed corner cases
    step(1, mk(2, 3, 9));            // R6 halt core 3
    step(1, mk(0, 3, 6'h2a));        // R3 post to halted core, run stays clear
    step(0, '0);                     // R9 idle, hold cmd fields
    step(1, mk(3, 3, 0));            // R7 resume
    step(1, mk(2, 7, 1));            // R6 top installed core
    step(1, mk(1, 7, POR));          // R4 start with power-on code
    step(1, mk(1, 2, 6'h05));        // R5 refused start
    step(0, '0);
    step(1, mk(2, 8, 0));            // R8 first uninstalled core
    step(1, mk(3, 31, 0));           // R8 top core number
    step(1, mk(1, 9, 6'h07));        // R8 no error from out-of-range
    step(1, 18'h0_e0c0 | mk(2, 1, 3)); // R2 junk in unused bits
    step(1, 18'h0_e0c0 | mk(0, 5, 6'h3f)); // R2
    step(1, 18'h0_e0c0 | mk(3, 1, 3)); // R2

    doReset();   // R10 clears only by reset

    for (int i = 0; i < 4000; i++) begin
      int k = $urandom_range(3, 0);
      int c = ($urandom_range(3, 0) == 0) ? $urandom_range(31, 0) : $urandom_range(NUM-1, 0);
      int v = ($urandom_range(1, 0) == 1) ? int'(POR) : $urandom_range(63, 0);
      logic [17:0] d = mk(k, c, v) | (18'(($urandom() & 32'h0000_e0c0)));
      step($urandom_range(3, 0) != 0, d);
      if (i == 2000) doReset();
    end
    step(0, '0);
    step(0, '0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule